// File: doc/BRIEF.md
# Lockable Reset Watchdog Timer

This block is a watchdog counter that software programs through a small register port. It can pull a system reset line. The counter counts down on a slow tick enable, nominally 32768 ticks per second, so one count is about 30.5 µs. Software loads a timeout, starts the counter and reloads it from time to time. If software stops reloading it, the counter expires and, when reset mode is selected, the block drives a reset pulse of fixed length.

The load and control registers are guarded by a key register. These registers only accept a write after the 16-bit key 0xE551 has been written to the key register. Any other value written there closes them again. Reads are never blocked. The timeout is held as two 16-bit halves. A wide-mode control bit chooses between the full 32-bit value and the low half on its own. Starting the counter and enabling the reset are two separate control bits.

Top module: `lock_wdog_top`

## Requirements
- R1: After reset, reads return 0xFFFF at offsets 0x80 and 0x84, 0x0000 at 0x88 and 0x0000 at 0xA0. The reset output is low and the block is locked.
- R2: Writing 0xE551 to offset 0xA0 unlocks the block, and 0xA0 then reads 0x0001. Writing any other value there, for example 0x1AAE, locks it again, and 0xA0 then reads 0x0000.
- R3: While the block is locked, writes to offsets 0x80 (load low half), 0x84 (load high half) and 0x88 (control) are ignored, and readback shows the old contents.
- R4: At offset 0x88, bit 1 is run, bit 2 is wide mode and bit 3 is reset enable. These bits read back as written. All other bits read as 0.
- R5: A control write that takes run from 0 to 1 loads the counter. Only cycles with tick high count. Expiry happens on the N-th tick after the load, where N is the load value, and a load of 0 behaves like 1.
- R6: With wide mode set, the load value is {high half, low half}. With wide mode clear, it is the low half alone and the high half is ignored.
- R7: If reset enable is set at expiry, the reset output is high for exactly 4 consecutive clock cycles, starting the cycle after the expiring tick. If reset enable is clear, the reset output stays low.
- R8: Expiry clears the run bit, so the counter stops and further ticks produce no pulse.
- R9: While running, a write to the low half reloads the counter from the load value, which restarts the full timeout.
- R10: Read data is registered and follows the address presented one clock earlier. Unmapped offsets read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one pulse per timer tick |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| wdog_rst | output | 1 | Registered reset pulse on expiry |

## Verification
The assertions check several properties on every cycle. A locked write to a load half changes nothing. A reload leaves the counter at the load value. The counter holds its value on cycles without a tick. Expiry clears run. Every reset pulse is exactly 4 cycles long. Other properties need sequences of register writes, reads and counted ticks, so only the bench's scenarios show them: the key and relock behaviour, the tick on which expiry lands, wide versus narrow timeouts, the kick that restarts the count, and the silent expiry when reset enable is clear.

// File: rtl/lock_wdog_pkg.sv
package lock_wdog_pkg;
  localparam int ADDR_W = 8;
  localparam int HALF_W = 16;
  localparam int LOAD_W = 2 * HALF_W;

  // register byte offsets decoded by software
  localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_KEY     = 8'hA0;

  localparam logic [HALF_W-1:0] OPEN_KEY = 16'hE551;

  // control bit positions
  localparam int CB_RUN  = 1;
  localparam int CB_WIDE = 2;
  localparam int CB_RSTE = 3;

  localparam int PULSE_CYC = 4;
endpackage

// File: rtl/lock_wdog_regs.sv
module lock_wdog_regs
  import lock_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wdata,
  input  logic              expire_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic [LOAD_W-1:0] load_val_o,
  output logic              run_o,
  output logic              rste_o,
  output logic              reload_o
);
  logic              open_q;
  logic [HALF_W-1:0] lo_q, hi_q, rdata_q, rd_mux, ctrl_view;
  logic              run_q, wide_q, rste_q, reload_q;
  logic              wr_lo, wr_hi, wr_ctrl, wr_key;

  assign wr_key  = we && (addr == OFS_KEY);
  assign wr_lo   = we && open_q && (addr == OFS_LOAD_LO);
  assign wr_hi   = we && open_q && (addr == OFS_LOAD_HI);
  assign wr_ctrl = we && open_q && (addr == OFS_CTRL);

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[CB_RUN]  = run_q;
    ctrl_view[CB_WIDE] = wide_q;
    ctrl_view[CB_RSTE] = rste_q;
  end

  always_comb begin
    case (addr)
      OFS_LOAD_LO: rd_mux = lo_q;
      OFS_LOAD_HI: rd_mux = hi_q;
      OFS_CTRL:    rd_mux = ctrl_view;
      OFS_KEY:     rd_mux = {{(HALF_W-1){1'b0}}, open_q};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      lo_q     <= '1;
      hi_q     <= '1;
      run_q    <= 1'b0;
      wide_q   <= 1'b0;
      rste_q   <= 1'b0;
      reload_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      reload_q <= (wr_ctrl && wdata[CB_RUN] && !run_q) || (wr_lo && run_q);
      rdata_q  <= rd_mux;
      if (wr_key) open_q <= (wdata == OPEN_KEY);
      if (wr_lo)  lo_q <= wdata;
      if (wr_hi)  hi_q <= wdata;
      if (wr_ctrl) begin
        run_q  <= wdata[CB_RUN];
        wide_q <= wdata[CB_WIDE];
        rste_q <= wdata[CB_RSTE];
      end else if (expire_i) begin
        run_q <= 1'b0;
      end
    end
  end

  assign rdata_o    = rdata_q;
  assign load_val_o = wide_q ? {hi_q, lo_q} : {{HALF_W{1'b0}}, lo_q};
  assign run_o      = run_q;
  assign rste_o     = rste_q;
  assign reload_o   = reload_q;

  // R3
  locked_lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !open_q && addr == OFS_LOAD_LO) |=> $stable(lo_q));

  // R8
  expire_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_i && !(we && open_q && addr == OFS_CTRL)) |=> !run_q);
endmodule

// File: rtl/lock_wdog_counter.sv
module lock_wdog_counter
  import lock_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              reload_i,
  input  logic [LOAD_W-1:0] load_val_i,
  output logic              expire_o
);
  logic [LOAD_W-1:0] cnt_q;

  assign expire_o = run_i && tick_i && !reload_i && (cnt_q <= LOAD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (reload_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && tick_i) begin
      if (expire_o) cnt_q <= '0;
      else          cnt_q <= cnt_q - LOAD_W'(1);
    end
  end

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (rst)
    reload_i |=> (cnt_q == $past(load_val_i)));

  // R5
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lock_wdog_pulse.sv
module lock_wdog_pulse #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  logic [CW-1:0] left_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      out_q  <= 1'b0;
    end else if (trig_i) begin
      left_q <= CW'(PULSE_CYC - 1);
      out_q  <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - CW'(1);
      out_q  <= 1'b1;
    end else begin
      out_q  <= 1'b0;
    end
  end

  assign pulse_o = out_q;

  logic [CW:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst)        hi_len <= '0;
    else if (out_q) hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_q) |-> (hi_len == (CW+1)'(PULSE_CYC)));

  // R7
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |=> out_q);
endmodule

// File: rtl/lock_wdog_top.sv
module lock_wdog_top
  import lock_wdog_pkg::*;
#(
  parameter int RST_PULSE = PULSE_CYC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              wdog_rst
);
  logic [LOAD_W-1:0] load_val;
  logic run, rste, reload, expire;

  lock_wdog_regs u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .expire_i(expire), .rdata_o(bus_rdata), .load_val_o(load_val),
    .run_o(run), .rste_o(rste), .reload_o(reload)
  );

  lock_wdog_counter u_cnt (
    .clk(clk), .rst(rst), .run_i(run), .tick_i(tick), .reload_i(reload),
    .load_val_i(load_val), .expire_o(expire)
  );

  lock_wdog_pulse #(.PULSE_CYC(RST_PULSE)) u_pulse (
    .clk(clk), .rst(rst), .trig_i(expire && rste), .pulse_o(wdog_rst)
  );
endmodule

// File: tb/lock_wdog_top_test.sv
module lock_wdog_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        wdog_rst;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_wdog_top uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_rst(wdog_rst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string req);
    logic [15:0] v;
    rd(a, v);
    check(v == exp, req, v, exp);
  endtask

  // returns index of the first tick after which the reset output was seen high
  task automatic ticks(input int n, output int first_hi);
    first_hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (wdog_rst && first_hi == 0) first_hi = i + 1;
    end
  endtask

  task automatic pulse_len(output int len);
    len = wdog_rst ? 1 : 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (wdog_rst) len++;
    end
  endtask

  task automatic t_reset;
    check(wdog_rst == 1'b0, "R1 reset out", wdog_rst, 0);
    rd_chk(8'h80, 16'hFFFF, "R1 load lo");
    rd_chk(8'h84, 16'hFFFF, "R1 load hi");
    rd_chk(8'h88, 16'h0000, "R1 ctrl");
    rd_chk(8'hA0, 16'h0000, "R1 key");
  endtask

  task automatic t_lock;
    wr(8'h80, 16'h1234);
    rd_chk(8'h80, 16'hFFFF, "R3 locked lo write");
    wr(8'h84, 16'h0042);
    rd_chk(8'h84, 16'hFFFF, "R3 locked hi write");
    wr(8'hA0, 16'hE551);
    rd_chk(8'hA0, 16'h0001, "R2 unlocked");
    wr(8'h80, 16'h1234);
    rd_chk(8'h80, 16'h1234, "R2 open lo write");
    wr(8'hA0, 16'h1AAE);
    rd_chk(8'hA0, 16'h0000, "R2 relocked");
    wr(8'h80, 16'h5555);
    rd_chk(8'h80, 16'h1234, "R3 relocked lo write");
    wr(8'h88, 16'h000A);
    rd_chk(8'h88, 16'h0000, "R3 locked ctrl write");
    wr(8'hA0, 16'hE551);
  endtask

  task automatic t_ctrl_bits;
    wr(8'h88, 16'hFFFC);
    rd_chk(8'h88, 16'h000C, "R4 ctrl bits");
    wr(8'h88, 16'h0000);
    rd_chk(8'h88, 16'h0000, "R4 ctrl clear");
  endtask

  task automatic t_unmapped;
    rd_chk(8'h00, 16'h0000, "R10 unmapped");
    rd_chk(8'h84, 16'hFFFF, "R10 registered read");
  endtask

  task automatic t_expire_reset;
    int h, len;
    wr(8'h80, 16'd3);
    wr(8'h88, 16'h000A);
    repeat (20) @(negedge clk);
    check(wdog_rst == 1'b0, "R5 no tick no count", wdog_rst, 0);
    ticks(2, h);
    check(h == 0, "R5 early", h, 0);
    ticks(1, h);
    check(h == 1, "R5 third tick expires", h, 1);
    pulse_len(len);
    check(len == 4, "R7 pulse length", len, 4);
    rd_chk(8'h88, 16'h0008, "R8 run cleared");
    ticks(5, h);
    check(h == 0, "R8 stopped", h, 0);
  endtask

  task automatic t_noreset;
    int h, len;
    wr(8'h80, 16'd2);
    wr(8'h88, 16'h0002);
    ticks(2, h);
    pulse_len(len);
    check(h == 0 && len == 0, "R7 no reset when disabled", len, 0);
    rd_chk(8'h88, 16'h0000, "R8 run cleared no reset");
  endtask

  task automatic t_zero_load;
    int h, len;
    wr(8'h80, 16'd0);
    wr(8'h88, 16'h000A);
    ticks(1, h);
    check(h == 1, "R5 zero load", h, 1);
    pulse_len(len);
  endtask

  task automatic t_wide;
    int h, len;
    wr(8'h84, 16'd1);
    wr(8'h80, 16'd3);
    wr(8'h88, 16'h000E);
    ticks(20, h);
    check(h == 0, "R6 wide uses high half", h, 0);
    wr(8'h88, 16'h0000);
    wr(8'h88, 16'h000A);
    ticks(2, h);
    check(h == 0, "R6 narrow early", h, 0);
    ticks(1, h);
    check(h == 1, "R6 narrow ignores high half", h, 1);
    pulse_len(len);
  endtask

  task automatic t_kick;
    int h, len;
    wr(8'h84, 16'd0);
    wr(8'h80, 16'd5);
    wr(8'h88, 16'h000A);
    ticks(3, h);
    wr(8'h80, 16'd5);
    ticks(4, h);
    check(h == 0, "R9 kick restarts", h, 0);
    ticks(1, h);
    check(h == 1, "R9 expiry after kick", h, 1);
    pulse_len(len);
    check(len == 4, "R7 pulse after kick", len, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lock();
    t_ctrl_bits();
    t_unmapped();
    t_expire_reset();
    t_noreset();
    t_zero_load();
    t_wide();
    t_kick();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule